// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is one stage of a synchronous binary up-counter, four bits wide by default. All state bits share one clock and change on the same rising edge. The stage can be preset from a parallel data input, held, advanced by one, or forced to zero at any moment by an asynchronous active-low clear.

Two count enables gate the advance. The stage counts only when both are high. Only the second enable also gates the carry output, and that carry goes high when the count is at its all-ones value. Feeding one stage's carry into the next stage's carry-gating enable builds a wider synchronous counter with no glue logic. The stages share the clock, the load and the first enable.

Top module: `ccnt_stage`

## Requirements
- R1: All state bits change on the same rising clock edge. A step from 7 to 8 in the low stage (every bit toggles) appears complete one edge later, with no intermediate value.
- R2: While `clr_n` is 0 the count is 0. This takes effect without waiting for a clock edge, and it holds regardless of `load_n`, `en_p` and `en_t`.
- R3: When `load_n` is 0 and `clr_n` is 1, the next rising edge copies `din` into `q` for any values of `en_p` and `en_t`.
- R4: When `load_n` is 1 and `en_p` and `en_t` are both 1, each rising edge adds one to `q`.
- R5: When `load_n` is 1 and either `en_p` or `en_t` is 0, `q` keeps its value across the edge.
- R6: `rco` is 1 exactly when `en_t` is 1 and `q` is all ones. It does not depend on `en_p`, and it follows a change of `en_t` within the same cycle, with no clock edge.
- R7: The count wraps from all ones to zero.
- R8: Two stages form an 8-bit counter when the low stage's `rco` drives the high stage's `en_t`. That counter counts up through 255 and wraps to 0.
- R9: The priority is clear, then load, then count, then hold. A load requested while clear is low has no effect.
- R10: After `clr_n` returns to 1, the first rising edge already applies load or count normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel preset, active low |
| din | input | W (4) | Preset value |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | W (4) | Current count |
| rco | output | 1 | Carry: high when `en_t` is high and `q` is all ones |

## Verification
Load, count and hold results take exactly one rising edge. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, so each sample sees exactly one update. Clear and the carry are not registered. The bench checks them a fraction of a cycle after it changes `clr_n` or `en_t`, with no clock edge in between, which shows they do not wait for the clock. The 8-bit chain checks that the carry from the low stage reaches the high stage's enable in the cycle before the edge where both stages roll over.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;

    // Next-state operation of one counter stage, in priority order below clear.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    // Synchronous control inputs of a stage, grouped.
    typedef struct packed {
        logic load_n;
        logic en_p;
        logic en_t;
    } ctl_t;

    // Load outranks counting; counting needs both enables.
    function automatic op_e pick_op(ctl_t c);
        if (!c.load_n)
            return OP_LOAD;
        if (c.en_p && c.en_t)
            return OP_COUNT;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/ccnt_opsel.sv
module ccnt_opsel
    import ccnt_pkg::*;
(
    input  ctl_t ctl,
    output op_e  op
);

    always_comb begin
        op = pick_op(ctl);
    end

endmodule

// File: rtl/ccnt_state.sv
module ccnt_state
    import ccnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  op_e          op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  q <= din;
                OP_COUNT: q <= q + ONE;
                default:  q <= q;
            endcase
        end
    end

    // R2 / R9: the state reads zero at any edge while clear is held
    assert_clear_zero_R2: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

    // R3: a load places the sampled data in the state
    assert_load_copy_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_LOAD) |=> (q == $past(din)));

    // R4 / R7: counting adds one modulo 2^W
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_COUNT) |=> (q == W'($past(q) + ONE)));

    // R5: hold keeps the state
    assert_hold_keep_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_HOLD) |=> $stable(q));

endmodule

// File: rtl/ccnt_carry.sv
module ccnt_carry #(
    parameter int W = 4
) (
    input  logic         en_t,
    input  logic [W-1:0] q,
    output logic         rco
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        rco = en_t && (q == TOP);
    end

endmodule

// File: rtl/ccnt_stage.sv
module ccnt_stage
    import ccnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         rco
);

    ctl_t ctl;
    op_e  op;

    assign ctl = '{load_n: load_n, en_p: en_p, en_t: en_t};

    ccnt_opsel u_opsel (
        .ctl (ctl),
        .op  (op)
    );

    ccnt_state #(.W(W)) u_state (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .q     (q)
    );

    ccnt_carry #(.W(W)) u_carry (
        .en_t (en_t),
        .q    (q),
        .rco  (rco)
    );

    // R6: carry is never raised without the carry-gating enable
    assert_carry_gated_R6: assert property (@(posedge clk) disable iff (!clr_n)
        rco |-> en_t);

    // R6: carry only at the terminal count
    assert_carry_terminal_R6: assert property (@(posedge clk) disable iff (!clr_n)
        rco |-> (&q));

    // R9: load wins over any enable pattern at the port level
    assert_load_first_R9: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n && en_p && en_t) |=> (q == $past(din)));

endmodule

// File: tb/ccnt_stage_tb_top.sv
`timescale 1ns/100ps
module ccnt_stage_tb_top;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic       p = 1'b0;
    logic       t = 1'b0;
    logic [7:0] din = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       rco_lo, rco_hi;
    wire  [7:0] q8 = {q_hi, q_lo};

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccnt_stage #(.W(4)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[3:0]),
        .en_p(p), .en_t(t), .q(q_lo), .rco(rco_lo)
    );

    ccnt_stage #(.W(4)) dut_hi_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[7:4]),
        .en_p(p), .en_t(rco_lo), .q(q_hi), .rco(rco_hi)
    );

    typedef struct packed {
        logic       ld_n;
        logic       p;
        logic       t;
        logic [7:0] din;
        logic [7:0] exp_q;
        logic       exp_rco;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'hFC, 8'hFC, 1'b0}, // load
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFD, 1'b0}, // count
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFE, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // carry at 255
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // 8-bit wrap
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0}, // hold, P low
        '{1'b0, 1'b1, 1'b1, 8'h3E, 8'h3E, 1'b0}, // load beats enables
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h3F, 1'b1},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h40, 1'b0}, // high stage advances
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'h40, 1'b0}, // hold, T low
        '{1'b0, 1'b0, 1'b0, 8'h1F, 8'h1F, 1'b0}, // carry gated by T
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h1F, 1'b1}, // carry ignores P
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h20, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h07, 8'h07, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h08, 1'b0}  // all low bits flip
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state under clear (R2)
        #1 clr_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R2 reset count", q8, 8'h00);
        chk("R2 reset carry", {7'b0, rco_lo}, 8'h00);
        @(negedge clk) clr_n = 1'b1;

        // table walk: drive on falling edge, check 1 ns after rising edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load_n = VECS[i].ld_n;
            p      = VECS[i].p;
            t      = VECS[i].t;
            din    = VECS[i].din;
            @(posedge clk);
            #1;
            chk($sformatf("R3/R4/R5/R7/R8 step %0d count", i), q8, VECS[i].exp_q);
            chk($sformatf("R6 step %0d carry", i), {7'b0, rco_lo}, {7'b0, VECS[i].exp_rco});
        end
        chk("R1 7 to 8 in one edge", q8, 8'h08);

        // R2: asynchronous clear mid-cycle, no edge needed
        @(negedge clk);
        load_n = 1'b1; p = 1'b1; t = 1'b1;
        @(posedge clk);
        #1 clr_n = 1'b0;
        #0.5;
        chk("R2 async clear without edge", q8, 8'h00);

        // R9: load requested under clear is ignored
        @(negedge clk);
        load_n = 1'b0; din = 8'hAA;
        @(posedge clk);
        #1;
        chk("R9 clear beats load", q8, 8'h00);

        // R10: first edge after release applies the load
        @(negedge clk) clr_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 load on first edge after clear", q8, 8'hAA);

        // R6: carry follows T with no clock edge
        @(negedge clk);
        load_n = 1'b0; din = 8'h0F; t = 1'b0; p = 1'b0;
        @(posedge clk);
        #1;
        load_n = 1'b1;
        chk("R6 carry low while T low", {7'b0, rco_lo}, 8'h00);
        t = 1'b1;
        #0.5;
        chk("R6 carry rises with T", {7'b0, rco_lo}, 8'h01);
        t = 1'b0;
        #0.5;
        chk("R6 carry falls with T", {7'b0, rco_lo}, 8'h00);
        @(posedge clk);
        #1;
        chk("R5 hold while carry toggled", q8, 8'h0F);

        // R7: low stage alone wraps 15 to 0, high nibble advances via carry
        @(negedge clk);
        p = 1'b1; t = 1'b1;
        @(posedge clk);
        #1;
        chk("R7 nibble wrap with carry into high", q8, 8'h10);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule